// File: doc/BRIEF.md
# Burst-Clock Packet Retiming Bridge

This block takes 8-bit transport-stream bytes that arrive on a gated source clock, buffers them, and sends them out again on a free-running local clock of the same nominal rate. The source clock toggles only while a packet is being sent. Because of this, nothing on the capture side may rely on further edges after the last byte of a burst. The two clocks have no phase relationship and may drift slightly against each other. A dual-clock FIFO absorbs that drift. Its write and read pointers cross between the domains as Gray code.

On the local side, a sequencer reads whole 188-byte packets out of the FIFO. It starts a packet only when all of its bytes are already buffered. It then streams those bytes on consecutive cycles with a valid strobe, and marks the first byte with a one-cycle sync strobe. Each first byte is compared with the sync byte 0x47, and a sticky flag records any mismatch. A sticky overflow flag in the source domain records bytes that were lost because the FIFO was full.

Neither stream port can apply back-pressure. On the input side, the source owns the clock, so `wvalid_i` has no ready partner: a byte is taken on every rising `wclk_i` edge where `wvalid_i` is high and the FIFO has room, and it is dropped otherwise. On the output side, `rvalid_o` also has no ready partner: the consumer must accept one byte on every `rclk_i` cycle where `rvalid_o` is high.

Top module: `ts_burst_retimer`

## Requirements
- R1: Bytes that the FIFO accepts come out on `rdata_o` in the order they were written, with no loss or duplication.
- R2: A packet starts only when at least 188 bytes are buffered. Once it has started, `rvalid_o` stays high for exactly 188 consecutive `rclk_i` cycles.
- R3: `rsync_o` is high for exactly one cycle per packet, in the same cycle as the packet's first byte, and is never high without `rvalid_o`.
- R4: `rsync_err_o` rises in the cycle in which a packet's first byte is not 0x47. It stays high until the read-side reset.
- R5: While no complete packet is buffered, `rvalid_o` and `rsync_o` stay low and `rdata_o` holds its last value. A partial packet is never emitted.
- R6: The FIFO holds 512 bytes. A byte presented while the FIFO is full is dropped, and `wovf_o` becomes high after that `wclk_i` edge and stays high.
- R7: Each domain has its own active-low reset, asserted asynchronously and released synchronously. After the read reset, `rdata_o`, `rvalid_o`, `rsync_o` and `rsync_err_o` are 0. After both resets, `wovf_o` is 0 and the FIFO is empty.
- R8: If the next packet is already complete when the last byte of a packet is read, the next packet's sync byte is output in the very next cycle, so that consecutive sync strobes are 188 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Gated source clock, toggles only during bursts |
| wrst_ni | input | 1 | Active-low reset of the source domain |
| wdata_i | input | 8 | Incoming byte |
| wvalid_i | input | 1 | Byte on `wdata_i` is taken on this `wclk_i` edge |
| wovf_o | output | 1 | Sticky flag: a byte was dropped because the FIFO was full |
| rclk_i | input | 1 | Free-running local clock |
| rrst_ni | input | 1 | Active-low reset of the local domain |
| rdata_o | output | 8 | Outgoing byte |
| rvalid_o | output | 1 | `rdata_o` carries a packet byte this cycle |
| rsync_o | output | 1 | First byte of a packet |
| rsync_err_o | output | 1 | Sticky flag: a packet's first byte was not 0x47 |

## Verification
The stimulus covers four patterns:
- A single packet whose last byte is held back while the source clock is stopped. This separates a sequencer that waits for a whole packet from one that starts on a partial one.
- Two packets written faster than they are read. This shows whether the sequencer chains packets without an idle cycle.
- A packet with a corrupted first byte. This exercises the sticky check of the sync byte.
- A 520-byte burst with the read side held in reset. This fills the FIFO, so the last eight bytes must be dropped and the overflow flag must rise. After the read side is released, exactly two packets must come out and the remaining partial packet must stay buffered.

// File: rtl/ts_retime_pkg.sv
package ts_retime_pkg;
  localparam int unsigned TS_BYTE_W  = 8;
  localparam int unsigned TS_PKT_LEN = 188;
  localparam logic [7:0]  TS_SYNC    = 8'h47;

  typedef enum logic {
    RD_IDLE = 1'b0,
    RD_PKT  = 1'b1
  } rd_state_e;
endpackage

// File: rtl/ts_rst_sync.sv
module ts_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) chain_q <= '0;
    else          chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/ts_gray_sync.sv
module ts_gray_sync #(
  parameter int W      = 10,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     stg_q[s] <= '0;
        else if (s == 0) stg_q[s] <= d_i;
        else             stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ts_dpram.sv
module ts_dpram #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/ts_fifo_wr.sv
module ts_fifo_wr #(
  parameter int AW = 9
) (
  input  logic          wclk_i,
  input  logic          wrst_ni,
  input  logic          wvalid_i,
  input  logic [AW:0]   rgray_sync_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW:0]   wgray_o,
  output logic          ovf_o
);
  logic [AW:0] wbin_q, wgray_q, wbin_nxt;
  logic        full, accept, ovf_q;

  // Full when the write pointer leads the read pointer by one whole lap.
  assign full     = (wgray_q == {~rgray_sync_i[AW:AW-1], rgray_sync_i[AW-2:0]});
  assign accept   = wvalid_i && !full;
  assign wbin_nxt = wbin_q + 1'b1;

  always_ff @(posedge wclk_i or negedge wrst_ni) begin
    if (!wrst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      if (accept) begin
        wbin_q  <= wbin_nxt;
        wgray_q <= wbin_nxt ^ (wbin_nxt >> 1);
      end
      if (wvalid_i && full) ovf_q <= 1'b1;
    end
  end

  assign we_o    = accept;
  assign waddr_o = wbin_q[AW-1:0];
  assign wgray_o = wgray_q;
  assign ovf_o   = ovf_q;

  p_gray_step_r1: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    $onehot0(wgray_q ^ $past(wgray_q)));
  p_drop_when_full_r6: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    (wvalid_i && full) |=> ($stable(wbin_q) && ovf_q));
  p_ovf_sticky_r6: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    ovf_q |=> ovf_q);
endmodule

// File: rtl/ts_pkt_reader.sv
module ts_pkt_reader
  import ts_retime_pkg::*;
#(
  parameter int          AW      = 9,
  parameter int          DW      = 8,
  parameter int          PKT_LEN = 188,
  parameter logic [DW-1:0] SYNC_B = 8'h47
) (
  input  logic          rclk_i,
  input  logic          rrst_ni,
  input  logic [AW:0]   wgray_sync_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] raddr_o,
  output logic [AW:0]   rgray_o,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o,
  output logic          rsync_o,
  output logic          sync_err_o
);
  localparam int          CNT_W   = $clog2(PKT_LEN);
  localparam logic [AW:0] PKT_CNT = (AW+1)'(PKT_LEN);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PKT_LEN - 1);

  rd_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [AW:0]      rbin_q, rgray_q, rbin_nxt, wbin_s, avail;
  logic [DW-1:0]    rdata_q;
  logic             rvalid_q, rsync_q, err_q;
  logic             go, first;

  generate
    for (genvar i = 0; i <= AW; i++) begin : g_g2b
      assign wbin_s[i] = ^(wgray_sync_i >> i);
    end
  endgenerate

  assign avail    = wbin_s - rbin_q;
  assign first    = (state_q == RD_IDLE);
  assign go       = !first || (avail >= PKT_CNT);
  assign rbin_nxt = rbin_q + 1'b1;

  always_ff @(posedge rclk_i or negedge rrst_ni) begin
    if (!rrst_ni) begin
      state_q  <= RD_IDLE;
      cnt_q    <= '0;
      rbin_q   <= '0;
      rgray_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      rsync_q  <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      rvalid_q <= go;
      rsync_q  <= go && first;
      if (go) begin
        rdata_q <= mem_rdata_i;
        rbin_q  <= rbin_nxt;
        rgray_q <= rbin_nxt ^ (rbin_nxt >> 1);
        if (first && (mem_rdata_i != SYNC_B)) err_q <= 1'b1;
        if (cnt_q == LAST) begin
          cnt_q   <= '0;
          state_q <= RD_IDLE;
        end else begin
          cnt_q   <= cnt_q + 1'b1;
          state_q <= RD_PKT;
        end
      end
    end
  end

  assign raddr_o    = rbin_q[AW-1:0];
  assign rgray_o    = rgray_q;
  assign rdata_o    = rdata_q;
  assign rvalid_o   = rvalid_q;
  assign rsync_o    = rsync_q;
  assign sync_err_o = err_q;

  p_sync_with_valid_r3: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    rsync_o |-> rvalid_o);
  p_run_starts_sync_r2: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    (rvalid_o && !$past(rvalid_o)) |-> rsync_o);
  p_idle_hold_r5: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    !rvalid_o |-> $stable(rdata_o));
  p_err_sticky_r4: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    sync_err_o |=> sync_err_o);
  p_err_on_sync_r4: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    $rose(sync_err_o) |-> rsync_o);
  p_rd_gray_step_r1: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    $onehot0(rgray_q ^ $past(rgray_q)));
endmodule

// File: rtl/ts_burst_retimer.sv
module ts_burst_retimer
  import ts_retime_pkg::*;
#(
  parameter int            ADDR_W  = 9,
  parameter int            DATA_W  = TS_BYTE_W,
  parameter int            PKT_LEN = TS_PKT_LEN,
  parameter logic [DATA_W-1:0] SYNC_B = TS_SYNC,
  parameter int            SYNC_STAGES = 2
) (
  input  logic              wclk_i,
  input  logic              wrst_ni,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wvalid_i,
  output logic              wovf_o,
  input  logic              rclk_i,
  input  logic              rrst_ni,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              rsync_o,
  output logic              rsync_err_o
);
  logic              wrst_n, rrst_n, we;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [ADDR_W:0]   wgray, rgray, wgray_s, rgray_s;
  logic [DATA_W-1:0] mem_rdata;

  ts_rst_sync #(.STAGES(SYNC_STAGES)) u_wrst (
    .clk_i(wclk_i), .arst_ni(wrst_ni), .rst_no(wrst_n));
  ts_rst_sync #(.STAGES(SYNC_STAGES)) u_rrst (
    .clk_i(rclk_i), .arst_ni(rrst_ni), .rst_no(rrst_n));

  ts_fifo_wr #(.AW(ADDR_W)) u_wr (
    .wclk_i(wclk_i), .wrst_ni(wrst_n), .wvalid_i(wvalid_i),
    .rgray_sync_i(rgray_s), .we_o(we), .waddr_o(waddr),
    .wgray_o(wgray), .ovf_o(wovf_o));

  ts_dpram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
    .wclk_i(wclk_i), .we_i(we), .waddr_i(waddr), .wdata_i(wdata_i),
    .raddr_i(raddr), .rdata_o(mem_rdata));

  ts_gray_sync #(.W(ADDR_W+1), .STAGES(SYNC_STAGES)) u_w2r (
    .clk_i(rclk_i), .rst_ni(rrst_n), .d_i(wgray), .q_o(wgray_s));
  ts_gray_sync #(.W(ADDR_W+1), .STAGES(SYNC_STAGES)) u_r2w (
    .clk_i(wclk_i), .rst_ni(wrst_n), .d_i(rgray), .q_o(rgray_s));

  ts_pkt_reader #(.AW(ADDR_W), .DW(DATA_W), .PKT_LEN(PKT_LEN), .SYNC_B(SYNC_B)) u_rd (
    .rclk_i(rclk_i), .rrst_ni(rrst_n), .wgray_sync_i(wgray_s),
    .mem_rdata_i(mem_rdata), .raddr_o(raddr), .rgray_o(rgray),
    .rdata_o(rdata_o), .rvalid_o(rvalid_o), .rsync_o(rsync_o),
    .sync_err_o(rsync_err_o));
endmodule

// File: tb/tb_ts_burst_retimer.sv
`timescale 1ns/100ps
module tb_ts_burst_retimer;
  logic       wclk = 0, wrst_n = 1, wvalid = 0, rclk = 0, rrst_n = 1;
  logic [7:0] wdata = 0;
  logic       wovf, rvalid, rsync, rerr;
  logic [7:0] rdata;

  ts_burst_retimer dut (
    .wclk_i(wclk), .wrst_ni(wrst_n), .wdata_i(wdata), .wvalid_i(wvalid),
    .wovf_o(wovf), .rclk_i(rclk), .rrst_ni(rrst_n), .rdata_o(rdata),
    .rvalid_o(rvalid), .rsync_o(rsync), .rsync_err_o(rerr));

  always #5 rclk = ~rclk;

  int checks = 0, errors = 0;
  logic [7:0] exp_q [$];
  int sync_cyc [$];
  int wr_acc = 0, rd_cnt = 0, pos = 0, cyc = 0;
  bit err_exp = 0, ovf_exp = 0, in_rrst = 0;
  logic [7:0] last_data = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
    end
  endtask

  // Cycle-level reference model of the read side
  always @(negedge rclk) begin
    cyc++;
    if (in_rrst) begin
      chk(!rvalid && !rsync && rdata == 0 && !rerr, "R7 read reset",
          {rvalid, rsync, rerr}, 0);
      pos = 0; err_exp = 0; last_data = 0;
    end else if (rvalid) begin
      if (exp_q.size() == 0) begin
        chk(0, "R1 unexpected byte", rdata, 0);
      end else begin
        logic [7:0] e;
        if (pos == 0) begin
          chk(exp_q.size() >= 188, "R2 start needs full packet", exp_q.size(), 188);
          sync_cyc.push_back(cyc);
        end
        e = exp_q.pop_front();
        chk(rdata == e, "R1 byte order", rdata, e);
        chk(rsync == (pos == 0), "R3 sync placement", rsync, pos == 0);
        if (pos == 0 && e != 8'h47) err_exp = 1;
        pos = (pos + 1) % 188;
        rd_cnt++;
      end
      last_data = rdata;
    end else begin
      chk(!rsync, "R3 sync without valid", rsync, 0);
      chk(pos == 0, "R2 gap inside packet", pos, 0);
      chk(rdata == last_data, "R5 idle data hold", rdata, last_data);
    end
    if (!in_rrst) chk(rerr == err_exp, "R4 sync error flag", rerr, err_exp);
  end

  task automatic wbyte(input logic [7:0] b, input realtime hp);
    wdata = b; wvalid = 1;
    #(hp);
    wclk = 1;
    if (wr_acc - rd_cnt < 512) begin
      exp_q.push_back(b); wr_acc++;
    end else ovf_exp = 1;
    #(hp);
    wclk = 0; wvalid = 0;
  endtask

  task automatic wburst(input int n, input int first_k, input logic [7:0] seed,
                        input bit bad, input realtime hp);
    for (int k = first_k; k < first_k + n; k++)
      wbyte((k % 188 == 0) ? (bad ? 8'h46 : 8'h47) : 8'(seed + k), hp);
  endtask

  task automatic widle(input int n);
    for (int i = 0; i < n; i++) begin
      #5 wclk = 1; #5 wclk = 0;
    end
  endtask

  task automatic both_reset;
    @(posedge rclk); #1 rrst_n = 0; wrst_n = 0; in_rrst = 1;
    widle(3);
    exp_q.delete(); wr_acc = 0; rd_cnt = 0; ovf_exp = 0;
    wrst_n = 1; widle(3);
  endtask

  task automatic rrelease;
    @(posedge rclk); #1 rrst_n = 1;
    @(negedge rclk); in_rrst = 0;
  endtask

  task automatic drain(input int keep);
    for (int i = 0; i < 4000 && (exp_q.size() > keep || pos != 0); i++) @(posedge rclk);
    repeat (20) @(posedge rclk);
  endtask

  initial begin
    repeat (100000) @(posedge rclk);
    errors++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", rd_cnt, wr_acc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R7: reset state
    both_reset;
    repeat (4) @(posedge rclk);
    #1 chk(wovf == 0, "R7 write reset", wovf, 0);
    rrelease;
    repeat (5) @(posedge rclk);

    // R5/R2: partial packet never emitted while source clock is stopped
    wburst(187, 0, 8'h10, 0, 5.2);
    repeat (40) @(posedge rclk);
    chk(rd_cnt == 0, "R5 partial packet held", rd_cnt, 0);
    wburst(1, 187, 8'h10, 0, 5.2);
    drain(0);
    chk(rd_cnt == 188, "R2 full packet length", rd_cnt, 188);

    // R8: two packets buffered faster than read, back-to-back output
    sync_cyc.delete();
    wburst(376, 0, 8'h55, 0, 2.0);
    drain(0);
    chk(sync_cyc.size() == 2, "R8 packet count", sync_cyc.size(), 2);
    if (sync_cyc.size() == 2)
      chk(sync_cyc[1] - sync_cyc[0] == 188, "R8 sync spacing",
          sync_cyc[1] - sync_cyc[0], 188);

    // R4: bad sync byte sets sticky flag
    wburst(188, 0, 8'h33, 1, 4.8);
    drain(0);
    #1 chk(rerr == 1, "R4 flag set", rerr, 1);
    wburst(188, 0, 8'h21, 0, 4.8);
    drain(0);
    #1 chk(rerr == 1, "R4 flag sticky", rerr, 1);

    // R6: fill with read side in reset, overflow drops tail
    both_reset;
    wburst(520, 0, 8'h77, 0, 5.0);
    #1 chk(wovf == 1, "R6 overflow flag", wovf, 1);
    chk(ovf_exp == 1 && wr_acc == 512, "R6 model accepted", wr_acc, 512);
    widle(4);
    #1 chk(wovf == 1, "R6 overflow sticky", wovf, 1);
    rrelease;
    drain(136);
    chk(rd_cnt == 376, "R6 bytes delivered", rd_cnt, 376);
    chk(exp_q.size() == 136, "R5 remainder held", exp_q.size(), 136);
    #1 chk(!rvalid, "R5 idle with partial", rvalid, 0);

    // R7: resets clear flags
    both_reset;
    #1 chk(wovf == 0, "R7 overflow cleared", wovf, 0);
    rrelease;
    repeat (5) @(posedge rclk);
    #1 chk(rerr == 0 && !rvalid, "R7 read flags cleared", rerr, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule